// File: doc/BRIEF.md
# Multi-format stereo audio serial receiver

This block takes a two-channel serial audio stream on one data line, framed by a bit clock and a word clock, and turns it into parallel left and right samples. Four framings are handled by the same datapath: I2S, left-justified, right-justified, and a DSP-style framing in which a frame-sync pulse marks each word. A 3-bit format input and a 2-bit word-size input choose the framing and the number of meaningful bits in each word.

The bit clock, word clock and data inputs are asynchronous to the block. All three are passed through synchronizers into the system clock domain, and the bit clock's edges are detected there. The system clock must therefore run several times faster than the bit clock. Each completed word is sign-extended to 24 bits. It is placed on the left or right output, and a one-cycle valid strobe for that channel is raised with it.

Top module: `serial_audio_rx`

## Requirements
- R1: With format code 000 (I2S), bits are sampled on rising bit-clock edges. A word clock level of 0 marks the left channel and 1 marks the right channel. The MSB is on the second rising edge after the word clock changes level, and the following bits come MSB first in two's complement.
- R2: With format code 011 (left-justified), bits are sampled on rising bit-clock edges. A word clock level of 1 marks the left channel. The MSB is on the first rising edge after the word clock changes level.
- R3: With format code 001 (right-justified), bits are sampled on rising bit-clock edges. A word clock level of 1 marks the left channel. The word's LSB is the last bit sampled before the word clock changes level, and the word is delivered when that change is seen.
- R4: With format code 010 (DSP), bits are sampled on falling bit-clock edges. A word begins at the first falling edge that sees the frame sync high after it was low, and the MSB is on the next falling edge. The frame sync may stay high while the MSB is sent.
- R5: In DSP format, successive words go to left, right, left and so on. The first word after reset is always left.
- R6: Word-size code 00 selects 24 bits, 01 selects 20 bits and 10 selects 16 bits. Bits outside the word's position in the half frame do not affect the delivered sample.
- R7: A delivered sample of N bits has bits 23 down to N equal to its bit N-1 (sign extension).
- R8: A format code with bit 2 set, or word-size code 11, produces no valid strobe on either channel.
- R9: After reset both samples read zero and both strobes are low. A half frame that was already in progress when reset was released is not delivered.
- R10: Each valid strobe lasts one system clock, and the two strobes are never high in the same cycle.
- R11: A sample output changes only in the cycle in which its own valid strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are oversampled with it |
| rst | input | 1 | Synchronous active-high reset |
| bclk_i | input | 1 | Serial bit clock, asynchronous |
| wclk_i | input | 1 | Word clock or frame sync, asynchronous |
| sdata_i | input | 1 | Serial data line, asynchronous |
| mode_i | input | 3 | Format select: 000 I2S, 001 right-justified, 010 DSP, 011 left-justified |
| wlen_i | input | 2 | Word size select: 00 24 bits, 01 20 bits, 10 16 bits |
| left_o | output | 24 | Last left sample, sign-extended |
| left_valid_o | output | 1 | One-cycle strobe marking a new left sample |
| right_o | output | 24 | Last right sample, sign-extended |
| right_valid_o | output | 1 | One-cycle strobe marking a new right sample |

## Verification
The checker watches, on every cycle, the strobe discipline (one cycle wide, never both channels at once) and the silence under reserved codes. It also checks sign extension of 16-bit and 20-bit samples and that each sample output holds its value between its own strobes. Whether the right bits land in the right channel depends on the framing. That covers the MSB offset of each format, the right-justified alignment to the word clock change, the DSP left/right alternation restarting at reset, and the dropped partial half frame after reset. Only the bench scenarios can show these: a scoreboard compares every delivered word against the value and channel the driver encoded, with junk bits placed in the slots outside each word.

// File: rtl/sarx_pkg.sv
package sarx_pkg;

    localparam int unsigned SAMPLE_W = 24;
    localparam int unsigned POS_W    = 6;

    typedef enum logic [2:0] {
        FMT_I2S = 3'b000,
        FMT_RJ  = 3'b001,
        FMT_DSP = 3'b010,
        FMT_LJ  = 3'b011
    } fmt_e;

    typedef enum logic [1:0] {
        WL_24  = 2'b00,
        WL_20  = 2'b01,
        WL_16  = 2'b10,
        WL_RSV = 2'b11
    } wlen_e;

    // One sampling event as seen by the framer
    typedef struct packed {
        logic take;       // shift this bit into the word register
        logic bit_v;      // the sampled data bit
        logic done_incl;  // word complete, including this bit
        logic done_excl;  // word complete, excluding this bit
        logic to_left;    // destination channel of the completed word
    } slot_evt_t;

    function automatic logic [POS_W:0] word_bits(input logic [1:0] wl);
        case (wl)
            WL_24:   return (POS_W+1)'(24);
            WL_20:   return (POS_W+1)'(20);
            WL_16:   return (POS_W+1)'(16);
            default: return '0;
        endcase
    endfunction

    function automatic logic cfg_legal(input logic [2:0] m, input logic [1:0] wl);
        return (m[2] == 1'b0) && (wl != WL_RSV);
    endfunction

    // Replicate bit n-1 of raw into all bits from n upward
    function automatic logic [SAMPLE_W-1:0] sign_fill(input logic [SAMPLE_W-1:0] raw,
                                                      input logic [POS_W:0] n);
        logic [SAMPLE_W-1:0] r;
        logic                sb;
        r  = raw;
        sb = 1'b0;
        for (int i = 0; i < SAMPLE_W; i++) begin
            if (i == int'(n) - 1) sb = raw[i];
        end
        if (n != '0) begin
            for (int i = 0; i < SAMPLE_W; i++) begin
                if (i >= int'(n)) r[i] = sb;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/sarx_sync.sv
module sarx_sync #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned WIDTH  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    generate
        for (genvar g = 0; g < WIDTH; g++) begin : g_bit
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], async_i[g]};
            end
            assign sync_o[g] = chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/sarx_framer.sv
module sarx_framer
    import sarx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bclk_s,
    input  logic       wclk_s,
    input  logic       sdata_s,
    input  logic [2:0] mode,
    input  logic [1:0] wlen,
    output slot_evt_t  evt
);

    logic             bclk_d;
    logic             w_prev_q;
    logic             primed_q;
    logic             armed_q;
    logic             dsp_right_q;
    logic [POS_W-1:0] pos_q;

    logic             is_dsp;
    logic             stb;
    logic             trig;
    logic [POS_W-1:0] pos;
    logic [POS_W:0]   n;
    logic [POS_W:0]   off;
    logic [POS_W:0]   pos_x;
    logic [POS_W:0]   hi;

    always_comb begin
        is_dsp = (mode == FMT_DSP);
        stb    = is_dsp ? (!bclk_s && bclk_d) : (bclk_s && !bclk_d);
        trig   = primed_q && (is_dsp ? (wclk_s && !w_prev_q) : (wclk_s != w_prev_q));

        if (trig)        pos = '0;
        else if (&pos_q) pos = pos_q;
        else             pos = pos_q + 1'b1;

        n     = word_bits(wlen);
        off   = (mode == FMT_I2S || is_dsp) ? (POS_W+1)'(1) : '0;
        pos_x = {1'b0, pos};
        hi    = off + n;

        evt       = '0;
        evt.bit_v = sdata_s;
        case (mode)
            FMT_RJ: begin
                // keep shifting; the word closes when the word clock flips
                evt.take      = stb;
                evt.done_excl = stb && trig && armed_q;
                evt.to_left   = w_prev_q;
            end
            FMT_I2S, FMT_LJ, FMT_DSP: begin
                evt.take      = stb && (armed_q || trig) && (pos_x >= off) && (pos_x < hi);
                evt.done_incl = evt.take && ((pos_x + (POS_W+1)'(1)) == hi);
                if (mode == FMT_I2S)     evt.to_left = !wclk_s;
                else if (mode == FMT_LJ) evt.to_left = wclk_s;
                else                     evt.to_left = !dsp_right_q;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_d      <= 1'b0;
            w_prev_q    <= 1'b0;
            primed_q    <= 1'b0;
            armed_q     <= 1'b0;
            dsp_right_q <= 1'b0;
            pos_q       <= '0;
        end else begin
            bclk_d <= bclk_s;
            if (stb) begin
                w_prev_q <= wclk_s;
                primed_q <= 1'b1;
                pos_q    <= pos;
                if (trig) armed_q <= 1'b1;
                if (is_dsp && evt.done_incl) dsp_right_q <= !dsp_right_q;
            end
        end
    end

endmodule

// File: rtl/sarx_assembler.sv
module sarx_assembler
    import sarx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  slot_evt_t           evt,
    input  logic                cfg_ok,
    input  logic [POS_W:0]      n,
    output logic [SAMPLE_W-1:0] left_q,
    output logic [SAMPLE_W-1:0] right_q,
    output logic                left_stb,
    output logic                right_stb
);

    logic [SAMPLE_W-1:0] sh_q;
    logic [SAMPLE_W-1:0] sh_nx;
    logic [SAMPLE_W-1:0] word;
    logic                fire;

    always_comb begin
        sh_nx = {sh_q[SAMPLE_W-2:0], evt.bit_v};
        word  = sign_fill(evt.done_incl ? sh_nx : sh_q, n);
        fire  = cfg_ok && (evt.done_incl || evt.done_excl);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q      <= '0;
            left_q    <= '0;
            right_q   <= '0;
            left_stb  <= 1'b0;
            right_stb <= 1'b0;
        end else begin
            left_stb  <= 1'b0;
            right_stb <= 1'b0;
            if (evt.take) sh_q <= sh_nx;
            if (fire) begin
                if (evt.to_left) begin
                    left_q   <= word;
                    left_stb <= 1'b1;
                end else begin
                    right_q   <= word;
                    right_stb <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
    import sarx_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bclk_i,
    input  logic                wclk_i,
    input  logic                sdata_i,
    input  logic [2:0]          mode_i,
    input  logic [1:0]          wlen_i,
    output logic [SAMPLE_W-1:0] left_o,
    output logic                left_valid_o,
    output logic [SAMPLE_W-1:0] right_o,
    output logic                right_valid_o
);

    localparam int unsigned LINES = 3;

    logic [LINES-1:0] line_s;
    slot_evt_t        evt;
    logic [POS_W:0]   n_bits;
    logic             cfg_ok;

    assign n_bits = word_bits(wlen_i);
    assign cfg_ok = cfg_legal(mode_i, wlen_i);

    sarx_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (LINES)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i ({sdata_i, wclk_i, bclk_i}),
        .sync_o  (line_s)
    );

    sarx_framer u_framer (
        .clk     (clk),
        .rst     (rst),
        .bclk_s  (line_s[0]),
        .wclk_s  (line_s[1]),
        .sdata_s (line_s[2]),
        .mode    (mode_i),
        .wlen    (wlen_i),
        .evt     (evt)
    );

    sarx_assembler u_asm (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .cfg_ok    (cfg_ok),
        .n         (n_bits),
        .left_q    (left_o),
        .right_q   (right_o),
        .left_stb  (left_valid_o),
        .right_stb (right_valid_o)
    );

endmodule

// File: rtl/sarx_checker.sv
module sarx_checker (
    input logic        clk,
    input logic        rst,
    input logic [2:0]  mode_i,
    input logic [1:0]  wlen_i,
    input logic [23:0] left_o,
    input logic [23:0] right_o,
    input logic        left_valid_o,
    input logic        right_valid_o
);

    AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (rst)
        !(left_valid_o && right_valid_o)); // R10

    AST_LEFT_PULSE: assert property (@(posedge clk) disable iff (rst)
        left_valid_o |=> !left_valid_o); // R10

    AST_RIGHT_PULSE: assert property (@(posedge clk) disable iff (rst)
        right_valid_o |=> !right_valid_o); // R10

    AST_RESERVED_SILENT: assert property (@(posedge clk) disable iff (rst)
        (mode_i[2] || wlen_i == 2'b11) |=> !(left_valid_o || right_valid_o)); // R8

    AST_FILL_16: assert property (@(posedge clk) disable iff (rst)
        (wlen_i == 2'b10) ##1 left_valid_o |-> (left_o[23:15] == '0 || left_o[23:15] == '1)); // R7

    AST_FILL_20: assert property (@(posedge clk) disable iff (rst)
        (wlen_i == 2'b01) ##1 right_valid_o |-> (right_o[23:19] == '0 || right_o[23:19] == '1)); // R7

    AST_LEFT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !left_valid_o |-> $stable(left_o)); // R11

    AST_RIGHT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !right_valid_o |-> $stable(right_o)); // R11

endmodule

bind serial_audio_rx sarx_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .mode_i        (mode_i),
    .wlen_i        (wlen_i),
    .left_o        (left_o),
    .right_o       (right_o),
    .left_valid_o  (left_valid_o),
    .right_valid_o (right_valid_o)
);

// File: tb/serial_audio_rx_tb.sv
module serial_audio_rx_tb;

    localparam int HALF  = 4;   // system clocks per bit-clock phase
    localparam int SLOTS = 32;  // bit clocks per half frame

    typedef struct packed {
        logic        is_left;
        logic [23:0] val;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bclk = 1'b0;
    logic        wclk = 1'b0;
    logic        sdata = 1'b0;
    logic [2:0]  mode_r = 3'b000;
    logic [1:0]  wlen_r = 2'b00;
    logic [23:0] left_o;
    logic [23:0] right_o;
    logic        left_valid_o;
    logic        right_valid_o;

    int    checks = 0;
    int    fails = 0;
    int    valid_cnt = 0;
    logic [31:0] seed = 32'h1234_5678;
    string cur_req = "R9";
    exp_t  exp_q[$];

    always #10 clk = ~clk;  // 50 MHz

    serial_audio_rx u_dut (
        .clk           (clk),
        .rst           (rst),
        .bclk_i        (bclk),
        .wclk_i        (wclk),
        .sdata_i       (sdata),
        .mode_i        (mode_r),
        .wlen_i        (wlen_r),
        .left_o        (left_o),
        .left_valid_o  (left_valid_o),
        .right_o       (right_o),
        .right_valid_o (right_valid_o)
    );

    function automatic int nbits(input logic [1:0] wl);
        case (wl)
            2'b00:   return 24;
            2'b01:   return 20;
            2'b10:   return 16;
            default: return 0;
        endcase
    endfunction

    function automatic logic [23:0] sext(input logic [23:0] v, input int n);
        logic signed [23:0] t;
        if (n == 0) return v;
        t = $signed(v << (24 - n));
        return t >>> (24 - n);
    endfunction

    task automatic next_rand();
        seed = seed * 32'd1103515245 + 32'd12345;
    endtask

    task automatic check(input logic ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    // Scoreboard monitor: every strobe must match the next expected word
    always @(negedge clk) begin
        if (!rst && (left_valid_o || right_valid_o)) begin
            exp_t e;
            valid_cnt++;
            check(!(left_valid_o && right_valid_o), "R10", "both strobes",
                  {30'd0, left_valid_o, right_valid_o}, 32'd0);
            if (exp_q.size() == 0) begin
                check(1'b0, cur_req, "unexpected word", {8'd0, left_valid_o ? left_o : right_o}, 32'd0);
            end else begin
                e = exp_q.pop_front();
                check(left_valid_o == e.is_left, cur_req, "channel",
                      {31'd0, left_valid_o}, {31'd0, e.is_left});
                check((left_valid_o ? left_o : right_o) == e.val, cur_req, "sample",
                      {8'd0, left_valid_o ? left_o : right_o}, {8'd0, e.val});
            end
        end
    end

    // One bit-clock period; data changes in the phase that is not sampled
    task automatic slot(input logic w, input logic d);
        @(negedge clk);
        bclk  = (mode_r == 3'b010);
        wclk  = w;
        sdata = d;
        repeat (HALF) @(negedge clk);
        bclk = (mode_r != 3'b010);
        repeat (HALF - 1) @(negedge clk);
    endtask

    task automatic send_half(input logic w, input logic is_left, input logic push);
        int          n;
        logic [23:0] val;
        logic        d;
        exp_t        e;
        n = nbits(wlen_r);
        next_rand();
        val = seed[31:8];
        if (n != 0) val = val & ((24'd1 << n) - 24'd1);
        if (push) begin
            e.is_left = is_left;
            e.val     = sext(val, n);
            exp_q.push_back(e);
        end
        for (int s = 0; s < SLOTS; s++) begin
            next_rand();
            d = seed[20];  // junk outside the word (R6)
            if (n != 0) begin
                case (mode_r)
                    3'b011: if (s < n) d = val[n - 1 - s];                     // LJ
                    3'b001: if (s >= SLOTS - n) d = val[SLOTS - 1 - s];        // RJ
                    default: if (s >= 1 && s <= n) d = val[n - s];             // I2S
                endcase
            end
            slot(w, d);
        end
    endtask

    task automatic send_dsp_word(input logic is_left);
        int          n;
        logic [23:0] val;
        logic        d;
        exp_t        e;
        n = nbits(wlen_r);
        next_rand();
        val = seed[31:8] & ((24'd1 << n) - 24'd1);
        e.is_left = is_left;
        e.val     = sext(val, n);
        exp_q.push_back(e);
        for (int s = 0; s < SLOTS; s++) begin
            next_rand();
            d = seed[20];
            if (s >= 1 && s <= n) d = val[n - s];
            slot(s <= 1, d);  // frame sync still high during the MSB (R4)
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        bclk = 1'b0;
        wclk = 1'b0;
        sdata = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic finish_scn(input string req);
        repeat (40) @(negedge clk);
        check(exp_q.size() == 0, req, "words still expected", exp_q.size(), 32'd0);
        exp_q.delete();
    endtask

    task automatic run_std(input logic [2:0] fmt, input logic [1:0] wl, input int frames,
                           input string req, input logic push);
        logic lvl;
        do_reset();
        mode_r  = fmt;
        wlen_r  = wl;
        cur_req = req;
        lvl = (fmt == 3'b000 || fmt[2]) ? 1'b0 : 1'b1;
        for (int k = 0; k < 3; k++) slot(!lvl, 1'b1);  // partial half frame (R9)
        for (int f = 0; f < frames; f++) begin
            send_half(lvl, 1'b1, push);
            send_half(!lvl, 1'b0, push);
        end
        for (int k = 0; k < 3; k++) slot(lvl, 1'b0);   // closes the last RJ word
        finish_scn(req);
    endtask

    task automatic run_dsp(input logic [1:0] wl, input int words, input string req);
        do_reset();
        mode_r  = 3'b010;
        wlen_r  = wl;
        cur_req = req;
        for (int k = 0; k < 2; k++) slot(1'b0, 1'b1);
        for (int w = 0; w < words; w++) send_dsp_word(w % 2 == 0);  // R5 alternation
        finish_scn(req);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        do_reset();
        @(negedge clk);
        // R9: reset state
        check(left_o == 24'd0 && right_o == 24'd0, "R9", "reset samples",
              {8'd0, left_o | right_o}, 32'd0);
        check(!left_valid_o && !right_valid_o, "R9", "reset strobes",
              {30'd0, left_valid_o, right_valid_o}, 32'd0);

        run_std(3'b000, 2'b00, 3, "R1/R6/R7", 1'b1);   // I2S 24 bit
        run_std(3'b000, 2'b10, 2, "R1/R6/R7", 1'b1);   // I2S 16 bit
        run_std(3'b011, 2'b01, 3, "R2/R6/R7", 1'b1);   // LJ 20 bit
        run_std(3'b011, 2'b00, 2, "R2/R6", 1'b1);      // LJ 24 bit
        run_std(3'b001, 2'b10, 3, "R3/R6/R9", 1'b1);   // RJ 16 bit
        run_std(3'b001, 2'b00, 2, "R3/R9", 1'b1);      // RJ 24 bit
        run_dsp(2'b00, 3, "R4/R5");
        run_dsp(2'b10, 2, "R4/R5/R7");                 // alternation restarted by reset

        // R8: reserved codes are silent
        valid_cnt = 0;
        run_std(3'b100, 2'b00, 2, "R8", 1'b0);
        check(valid_cnt == 0, "R8", "strobes with reserved format", valid_cnt, 32'd0);
        valid_cnt = 0;
        run_std(3'b000, 2'b11, 2, "R8", 1'b0);
        check(valid_cnt == 0, "R8", "strobes with reserved word size", valid_cnt, 32'd0);

        // R11: samples hold after traffic stops
        run_std(3'b011, 2'b10, 1, "R2/R11", 1'b1);
        begin
            logic [23:0] l0;
            l0 = left_o;
            for (int k = 0; k < 4; k++) slot(1'b1, 1'b1);  // new word never completes
            check(left_o == l0, "R11", "left held", {8'd0, left_o}, {8'd0, l0});
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule